// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a memory-mapped watchdog. A free-running down-counter reloads from a programmable load register. The first time the counter expires, the block raises an interrupt and starts a fresh count. If the counter expires again before software has cleared that interrupt, and the reset path is armed, the block drives a system reset request. That reset request stays asserted until the block's own reset clears it.

Software talks to the block over a plain register bus: a word address, a write strobe, write data and combinational read data. Every register write except a write to the lock register is gated by a lock. Writing the magic key to the lock register opens the other registers. Writing any other value to it closes them again. Firmware normally opens the lock, reprograms or services the timer, and closes the lock.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the block is unlocked. The control register is 0, the load register and the counter both hold 0xFFFFFFFF, and the raw interrupt, the interrupt output and the reset output are all 0.
- R2: Registers sit at these byte offsets: load 0x000, current count 0x004, control 0x008, interrupt clear 0x00C (write only), raw status 0x010, masked status 0x014, lock 0xC00. Status flags are in bit 0. Any other address reads 0.
- R3: Writing 0x1ACCE551 to the lock register unlocks the block, and writing any other value locks it. The lock register reads 1 while locked and 0 while unlocked.
- R4: While the block is locked, writes to the load, control and interrupt-clear registers have no effect.
- R5: A write to the load register loads the counter with the written value at the same clock edge.
- R6: Control bit 0 is the run enable. While it is set, the counter decreases by one each cycle. While it is clear, the counter holds its value.
- R7: When the counter is at 0 and running, the next edge reloads it from the load register and sets the raw interrupt. Expiries are therefore load+1 cycles apart.
- R8: A write to the interrupt-clear register clears the raw interrupt and reloads the counter from the load register.
- R9: The masked status, which also drives the interrupt output, is the raw interrupt ANDed with control bit 0.
- R10: An expiry that occurs while the raw interrupt is already set asserts the reset output if control bit 1 is set, and does not assert it if control bit 1 is clear. This also holds with a load value of 0.
- R11: Once asserted, the reset output stays at 1 until the block's reset. Writes to the interrupt-clear register do not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt, equal to the masked status |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
The bench exercises these corner cases and the failure each one would expose:

- **Counter sitting at zero.** The bench checks that a counter at zero has not yet expired. A design that fires one cycle early would shorten every period.
- **Second expiry with the reset path disarmed.** A design that ignores control bit 1 would reset the system here.
- **Load value of zero.** The counter expires on every edge, so the reset follows exactly two cycles after the load. An off-by-one in the zero handling would shift or lose that reset.
- **Clearing or disabling while the interrupt is pending.** Disabling must mask the interrupt without dropping the raw flag. A clear must reload the counter. Under the lock, both a clear and a load must be ignored. The bench also checks that an interrupt-clear write never releases a reset that is already asserted.

// File: rtl/wdog_pkg.sv
// Package wdog_pkg
// Shared constants and types for the two-stage watchdog.
// Assumes byte addressing with 32-bit registers.
package wdog_pkg;

    localparam int unsigned OFF_LOAD  = 'h000;
    localparam int unsigned OFF_COUNT = 'h004;
    localparam int unsigned OFF_CTRL  = 'h008;
    localparam int unsigned OFF_CLEAR = 'h00C;
    localparam int unsigned OFF_RAW   = 'h010;
    localparam int unsigned OFF_MASK  = 'h014;
    localparam int unsigned OFF_LOCK  = 'hC00;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

    // Control register fields
    typedef struct packed {
        logic rst_en;  // bit 1: arm the reset output
        logic run_en;  // bit 0: run the counter and unmask the interrupt
    } ctrl_t;

endpackage

// File: rtl/wdog_regs.sv
// Module wdog_regs
// Register file, write lock and read multiplexer for the watchdog.
// All writes except those to the lock register are dropped while locked.
// Assumes single-cycle write strobes; read data is combinational.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic              raw_i,
    output logic [DATA_W-1:0] load_o,
    output ctrl_t             ctrl_o,
    output logic              locked_o,
    output logic              load_wr_o,
    output logic              clear_wr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [DATA_W-1:0] LOAD_RESET = '1;

    logic sel_load, sel_count, sel_ctrl, sel_clear, sel_raw, sel_mask, sel_lock;
    logic open_wr;

    // Decode the byte address into register selects
    always_comb begin
        sel_load  = (addr_i == ADDR_W'(OFF_LOAD));
        sel_count = (addr_i == ADDR_W'(OFF_COUNT));
        sel_ctrl  = (addr_i == ADDR_W'(OFF_CTRL));
        sel_clear = (addr_i == ADDR_W'(OFF_CLEAR));
        sel_raw   = (addr_i == ADDR_W'(OFF_RAW));
        sel_mask  = (addr_i == ADDR_W'(OFF_MASK));
        sel_lock  = (addr_i == ADDR_W'(OFF_LOCK));
    end

    // A write reaches a guarded register only while the block is unlocked
    assign open_wr    = we_i && !locked_o;
    assign load_wr_o  = open_wr && sel_load;
    assign clear_wr_o = open_wr && sel_clear;

    // Lock flag: the key opens the block, any other value closes it
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_o <= 1'b0;
        else if (we_i && sel_lock)
            locked_o <= (wdata_i[31:0] != UNLOCK_KEY);
    end

    // Load register
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_o <= LOAD_RESET;
        else if (load_wr_o)
            load_o <= wdata_i;
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_o <= '0;
        else if (open_wr && sel_ctrl)
            ctrl_o <= ctrl_t'(wdata_i[1:0]);
    end

    // Read multiplexer; unmapped and write-only addresses read 0
    always_comb begin
        rdata_o = '0;
        unique case (1'b1)
            sel_load:  rdata_o = load_o;
            sel_count: rdata_o = count_i;
            sel_ctrl:  rdata_o = DATA_W'(ctrl_o);
            sel_raw:   rdata_o = DATA_W'(raw_i);
            sel_mask:  rdata_o = DATA_W'(raw_i && ctrl_o.run_en);
            sel_lock:  rdata_o = DATA_W'(locked_o);
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/wdog_core.sv
// Module wdog_core
// Down-counter with two-stage expiry. The first expiry sets the raw
// interrupt; an expiry with the interrupt still set raises a sticky reset
// request, if that path is armed. Bus-driven reloads take priority over
// counting in the same cycle.
module wdog_core
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl_i,
    input  logic [DATA_W-1:0] load_i,
    input  logic              load_wr_i,
    input  logic [DATA_W-1:0] load_new_i,
    input  logic              clear_wr_i,
    output logic [DATA_W-1:0] count_o,
    output logic              raw_o,
    output logic              sys_rst_o
);

    localparam logic [DATA_W-1:0] COUNT_RESET = '1;

    logic at_zero, expire;

    // Expiry only when running, at zero and not overridden by a bus reload
    always_comb begin
        at_zero = (count_o == '0);
        expire  = ctrl_i.run_en && at_zero && !load_wr_i && !clear_wr_i;
    end

    // Counter: load write, then clear reload, then count or expiry reload
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_o <= COUNT_RESET;
        else if (load_wr_i)
            count_o <= load_new_i;
        else if (clear_wr_i)
            count_o <= load_i;
        else if (expire)
            count_o <= load_i;
        else if (ctrl_i.run_en)
            count_o <= count_o - 1'b1;
    end

    // Raw interrupt: cleared by the clear register, set by any expiry
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_o <= 1'b0;
        else if (clear_wr_i)
            raw_o <= 1'b0;
        else if (expire)
            raw_o <= 1'b1;
    end

    // Reset request: second-stage expiry with the reset path armed; sticky
    always_ff @(posedge clk) begin
        if (!rst_n)
            sys_rst_o <= 1'b0;
        else if (expire && raw_o && ctrl_i.rst_en)
            sys_rst_o <= 1'b1;
    end

endmodule

// File: rtl/wdog_two_stage.sv
// Module wdog_two_stage
// Top level of the lockable two-stage watchdog: register file plus
// counter core. The interrupt output is the masked status.
// Assumes a synchronous active-low reset and a single clock domain.
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);

    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] count_q;
    ctrl_t             ctrl_q;
    logic              locked_q;
    logic              load_wr;
    logic              clear_wr;
    logic              raw_q;

    // Register file and lock
    wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .we_i       (bus_we),
        .wdata_i    (bus_wdata),
        .count_i    (count_q),
        .raw_i      (raw_q),
        .load_o     (load_q),
        .ctrl_o     (ctrl_q),
        .locked_o   (locked_q),
        .load_wr_o  (load_wr),
        .clear_wr_o (clear_wr),
        .rdata_o    (bus_rdata)
    );

    // Counter and two-stage expiry
    wdog_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl_q),
        .load_i     (load_q),
        .load_wr_i  (load_wr),
        .load_new_i (bus_wdata),
        .clear_wr_i (clear_wr),
        .count_o    (count_q),
        .raw_o      (raw_q),
        .sys_rst_o  (sys_rst_o)
    );

    // Interrupt output follows the masked status
    assign irq_o = raw_q && ctrl_q.run_en;

endmodule

// File: rtl/wdog_checker.sv
// Module wdog_checker
// Temporal properties of the watchdog, bound onto the top module.
module wdog_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              irq_o,
    input logic              sys_rst_o,
    input logic [DATA_W-1:0] load_q,
    input logic [DATA_W-1:0] count_q,
    input logic [1:0]        ctrl_bits,
    input logic              locked_q,
    input logic              raw_q
);

    // R11: a raised reset request never drops while out of reset
    assert_rst_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> sys_rst_o);

    // R10: the reset request rises only after an armed expiry with the interrupt pending
    assert_rst_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> ($past(raw_q) && $past(ctrl_bits[1]) && $past(count_q) == '0));

    // R7: the raw interrupt rises only from a zero count
    assert_raw_from_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> $past(count_q) == '0);

    // R6: with counting off and no bus write, the counter holds
    assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[0] && !bus_we) |=> $stable(count_q));

    // R4: a locked load write leaves the load register unchanged
    assert_locked_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && bus_we && bus_addr == ADDR_W'('h000)) |=> $stable(load_q));

    // R9: the interrupt line never shows while the counter is disabled
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (raw_q && ctrl_bits[0]));

endmodule

bind wdog_two_stage wdog_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_o),
    .load_q    (load_q),
    .count_q   (count_q),
    .ctrl_bits (ctrl_q),
    .locked_q  (locked_q),
    .raw_q     (raw_q)
);

// File: tb/tb_wdog_two_stage.sv
module tb_wdog_two_stage;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                            A_CLR = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014,
                            A_LOCK = 12'hC00, A_NONE = 12'h100;
    localparam logic [31:0] KEY = 32'h1ACCE551;
    localparam int NVEC = 20;
    // Vector layout: [80:77] requirement, [76] write, [75:64] addr, [63:32] data, [31:0] expected read
    localparam logic [80:0] VEC [NVEC] = '{
        {4'd1, 1'b0, A_LOAD, 32'h0, 32'hFFFF_FFFF},  // R1 load reset value
        {4'd1, 1'b0, A_CNT,  32'h0, 32'hFFFF_FFFF},  // R1 counter reset value
        {4'd1, 1'b0, A_CTRL, 32'h0, 32'h0},          // R1 control cleared
        {4'd1, 1'b0, A_RAW,  32'h0, 32'h0},          // R1 no raw interrupt
        {4'd3, 1'b0, A_LOCK, 32'h0, 32'h0},          // R3 unlocked after reset
        {4'd2, 1'b0, A_NONE, 32'h0, 32'h0},          // R2 unmapped reads 0
        {4'd5, 1'b1, A_LOAD, 32'h5, 32'h0},
        {4'd5, 1'b0, A_LOAD, 32'h0, 32'h5},          // R5 load stored
        {4'd5, 1'b0, A_CNT,  32'h0, 32'h5},          // R5 counter reloaded
        {4'd3, 1'b1, A_LOCK, 32'h1, 32'h0},
        {4'd3, 1'b0, A_LOCK, 32'h0, 32'h1},          // R3 locked
        {4'd4, 1'b1, A_LOAD, 32'h9, 32'h0},
        {4'd4, 1'b0, A_LOAD, 32'h0, 32'h5},          // R4 load write ignored
        {4'd4, 1'b1, A_CTRL, 32'h3, 32'h0},
        {4'd4, 1'b0, A_CTRL, 32'h0, 32'h0},          // R4 control write ignored
        {4'd3, 1'b1, A_LOCK, KEY,   32'h0},
        {4'd3, 1'b0, A_LOCK, 32'h0, 32'h0},          // R3 key unlocks
        {4'd3, 1'b1, A_LOCK, 32'h1ACCE550, 32'h0},
        {4'd3, 1'b0, A_LOCK, 32'h0, 32'h1},          // R3 near-key locks
        {4'd3, 1'b1, A_LOCK, KEY,   32'h0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_o;
    logic              sys_rst_o;
    int                n_run = 0;
    int                n_fail = 0;

    always #5 clk = ~clk;

    wdog_two_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a; #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 irq", irq_o, 0);
        check("R1 sys_rst", sys_rst_o, 0);
        // Vector walk: register map, lock and reset state
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
            else rd($sformatf("R%0d vec%0d", VEC[i][80:77], i), VEC[i][75:64], VEC[i][31:0]);
        end

        // Countdown and first expiry
        wr(A_CTRL, 32'h1);
        wr(A_LOAD, 32'h3);
        rd("R5 reload", A_CNT, 3);
        tick(3);
        rd("R7 zero not yet expired", A_CNT, 0);
        rd("R7 raw still low", A_RAW, 0);
        tick(1);
        rd("R7 raw set", A_RAW, 1);
        rd("R7 reloaded", A_CNT, 3);
        rd("R9 masked", A_MSK, 1);
        check("R9 irq", irq_o, 1);
        wr(A_CTRL, 32'h0);
        rd("R9 masked off", A_MSK, 0);
        check("R9 irq off", irq_o, 0);
        rd("R9 raw kept", A_RAW, 1);
        rd("R6 count", A_CNT, 2);
        tick(5);
        rd("R6 held", A_CNT, 2);
        wr(A_CTRL, 32'h1);
        wr(A_CLR, 32'h0);
        rd("R8 raw cleared", A_RAW, 0);
        rd("R8 reloaded", A_CNT, 3);
        tick(4);
        rd("R7 period", A_RAW, 1);
        tick(4);
        check("R10 disarmed no reset", sys_rst_o, 0);
        wr(A_CTRL, 32'h3);
        tick(2);
        check("R10 before expiry", sys_rst_o, 0);
        tick(1);
        check("R10 reset asserted", sys_rst_o, 1);
        tick(5);
        wr(A_CLR, 32'h0);
        check("R11 sticky", sys_rst_o, 1);
        do_reset();
        check("R11 cleared by reset", sys_rst_o, 0);
        rd("R1 load after reset", A_LOAD, 32'hFFFF_FFFF);

        // Load of zero: expiry every cycle
        wr(A_CTRL, 32'h3);
        wr(A_LOAD, 32'h0);
        tick(1);
        rd("R10 zero-load raw", A_RAW, 1);
        check("R10 zero-load first stage", sys_rst_o, 0);
        tick(1);
        check("R10 zero-load reset", sys_rst_o, 1);
        do_reset();

        // Clear ignored while locked
        wr(A_CTRL, 32'h1);
        wr(A_LOAD, 32'h2);
        tick(3);
        rd("R7 raw before lock", A_RAW, 1);
        wr(A_LOCK, 32'h1);
        wr(A_CLR, 32'h0);
        rd("R4 clear ignored", A_RAW, 1);
        rd("R3 lock reads 1", A_LOCK, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule